// File: doc/BRIEF.md
# Wide Accumulator Arithmetic Unit

This unit is the add/subtract datapath of a fixed-point signal processor with two 40-bit accumulators, here called A and B. Each accepted operation takes a destination accumulator, a source operand, a 3-bit opcode and a one-bit variant flag. It works out the result in combinational logic and writes the result and a six-bit status word back on the next rising clock edge. Sources are the two accumulators, the low or high 16-bit half of either 32-bit input word X or Y, either full 32-bit word, or a ready 40-bit product value.

Before the adder, every source is aligned to the 40-bit accumulator format. A 16-bit half is sign-extended into bits 31..16. A full 32-bit word is sign-extended without a shift. The long-add variant places a low half, unsigned, into bits 15..0. Loading a full 40-bit pattern into an accumulator is done with a move from the product input.

Top module: `wacc_alu`

## Requirements
- R1: While rst_n is low, both accumulators and all six status bits are zero.
- R2: src_sel codes: 0 = X bits 15..0, 1 = Y bits 15..0, 2 = X bits 31..16, 3 = Y bits 31..16 (each of these four sign-extended and placed in bits 31..16 with bits 15..0 zero), 4 = X and 5 = Y (sign-extended from bit 31), 6 = A, 7 = B, 8 = product input. Any other code gives a zero operand. dst_sel 0 selects A and 1 selects B.
- R3: op_code 0 writes dst + src and op_code 1 writes dst - src, both modulo 2^40, into the destination. The new value shows on acc_a/acc_b one clock edge after op_valid is sampled high.
- R4: op_code 0 with op_alt = 1 (long add) adds X bits 15..0 (src_sel 0) or Y bits 15..0 (src_sel 1) as an unsigned value in bits 15..0.
- R5: op_code 4 increments and op_code 5 decrements the destination. The step is 1 with op_alt = 0 and 0x10000 with op_alt = 1.
- R6: op_code 6 with op_alt = 0 writes the absolute value of the destination, taken as signed. With op_alt = 1 it writes the negation. The most negative value maps to itself and sets overflow.
- R7: op_code 2 (compare) sets the flags for dst - src and leaves both accumulators unchanged.
- R8: op_code 3 (move) writes src into the destination. op_code 7 with op_alt = 1 (test) sets the flags from src and writes nothing. Both clear carry and overflow.
- R9: op_code 7 with op_alt = 0 rounds the destination. It adds 0x8000, or 0 when bits 15..0 are exactly 0x8000 and bit 16 is clear (ties go to even), then clears bits 15..0.
- R10: flags bit 2 is set when the 40-bit result is zero and bit 3 copies result bit 39. Bit 4 is set when result bits 39..31 are not all equal. Bit 5 is set when result bit 31 equals bit 30.
- R11: flags bit 0 is the carry out of bit 39 for additions and "no borrow" for subtractions (1 for negation of zero, 0 for absolute value). Bit 1 is signed 40-bit overflow of the exact result.
- R12: When op_valid is low, accumulators and flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Execute the operation this cycle |
| op_code | input | 3 | Operation code |
| op_alt | input | 1 | Variant select within an opcode |
| dst_sel | input | 1 | Destination accumulator: 0 = A, 1 = B |
| src_sel | input | 4 | Source operand code |
| x_in | input | 32 | Input word X |
| y_in | input | 32 | Input word Y |
| prod_in | input | 40 | Packed product value |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| flags | output | 6 | Status: 0 carry, 1 overflow, 2 zero, 3 sign, 4 extension, 5 unnormalized |

## Verification
Every result of this unit, for both accumulators and the status word, is due exactly one rising edge after op_valid is sampled. Compare and test produce only the status change in that cycle, and an idle cycle must leave everything as it was. The driver applies each operation on a falling edge and queues its expected state just after the next rising edge. The monitor pops and compares on the following falling edge, so each comparison falls in the single cycle in which that operation's result is first visible and before the next operation can land.

// File: rtl/wacc_pkg.sv
`timescale 1ns/1ps
package wacc_pkg;
  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_SUB    = 3'd1,
    OP_CMP    = 3'd2,
    OP_MOVE   = 3'd3,
    OP_INC    = 3'd4,
    OP_DEC    = 3'd5,
    OP_ABSNEG = 3'd6,
    OP_RNDTST = 3'd7
  } wacc_op_e;

  typedef enum logic [3:0] {
    SRC_XL = 4'd0, SRC_YL = 4'd1, SRC_XH = 4'd2, SRC_YH = 4'd3,
    SRC_X  = 4'd4, SRC_Y  = 4'd5, SRC_A  = 4'd6, SRC_B  = 4'd7,
    SRC_P  = 4'd8
  } wacc_src_e;

  typedef struct packed {
    logic u;
    logic e;
    logic n;
    logic z;
    logic v;
    logic c;
  } wacc_flags_t;
endpackage

// File: rtl/wacc_src_align.sv
`timescale 1ns/1ps
module wacc_src_align
  import wacc_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int REG_W = 32
) (
  input  logic [3:0]       src_sel,
  input  logic [REG_W-1:0] x_in,
  input  logic [REG_W-1:0] y_in,
  input  logic [ACC_W-1:0] acc_a,
  input  logic [ACC_W-1:0] acc_b,
  input  logic [ACC_W-1:0] prod_in,
  output logic [ACC_W-1:0] src_val,
  output logic [ACC_W-1:0] low_val
);
  localparam int HALF_W = REG_W / 2;
  localparam int EXT_W  = ACC_W - REG_W;

  function automatic logic [ACC_W-1:0] place_half(input logic [HALF_W-1:0] h);
    return {{EXT_W{h[HALF_W-1]}}, h, {HALF_W{1'b0}}};
  endfunction

  function automatic logic [ACC_W-1:0] widen_word(input logic [REG_W-1:0] w);
    return {{EXT_W{w[REG_W-1]}}, w};
  endfunction

  function automatic logic [ACC_W-1:0] zext_half(input logic [HALF_W-1:0] h);
    return {{(ACC_W-HALF_W){1'b0}}, h};
  endfunction

  always_comb begin
    case (wacc_src_e'(src_sel))
      SRC_XL:  src_val = place_half(x_in[HALF_W-1:0]);
      SRC_YL:  src_val = place_half(y_in[HALF_W-1:0]);
      SRC_XH:  src_val = place_half(x_in[REG_W-1:HALF_W]);
      SRC_YH:  src_val = place_half(y_in[REG_W-1:HALF_W]);
      SRC_X:   src_val = widen_word(x_in);
      SRC_Y:   src_val = widen_word(y_in);
      SRC_A:   src_val = acc_a;
      SRC_B:   src_val = acc_b;
      SRC_P:   src_val = prod_in;
      default: src_val = '0;
    endcase
    case (wacc_src_e'(src_sel))
      SRC_XL:  low_val = zext_half(x_in[HALF_W-1:0]);
      SRC_YL:  low_val = zext_half(y_in[HALF_W-1:0]);
      default: low_val = '0;
    endcase
  end
endmodule

// File: rtl/wacc_arith.sv
`timescale 1ns/1ps
module wacc_arith
  import wacc_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int HALF_W = 16
) (
  input  logic [2:0]       op_code,
  input  logic             op_alt,
  input  logic [ACC_W-1:0] dst_val,
  input  logic [ACC_W-1:0] src_val,
  input  logic [ACC_W-1:0] low_val,
  output logic [ACC_W-1:0] res,
  output logic             carry,
  output logic             ovf,
  output logic             wr_en
);
  localparam int MSB = ACC_W - 1;
  localparam logic [ACC_W-1:0] STEP_ONE = ACC_W'(1);
  localparam logic [ACC_W-1:0] STEP_MID = ACC_W'(1) << HALF_W;
  localparam logic [ACC_W-1:0] RND_TERM = ACC_W'(1) << (HALF_W - 1);
  localparam logic [HALF_W-1:0] TIE_PAT = {1'b1, {(HALF_W-1){1'b0}}};

  function automatic logic [ACC_W:0] add_c(input logic [ACC_W-1:0] p,
                                           input logic [ACC_W-1:0] q,
                                           input logic cin);
    return {1'b0, p} + {1'b0, q} + {{ACC_W{1'b0}}, cin};
  endfunction

  function automatic logic add_ovf(input logic pm, input logic qm, input logic rm);
    return (pm == qm) && (rm != pm);
  endfunction

  logic [ACC_W:0]   sum_w;
  logic [ACC_W:0]   neg_w;
  logic [ACC_W-1:0] addend;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] term;

  always_comb begin
    step   = op_alt ? STEP_MID : STEP_ONE;
    term   = ((dst_val[HALF_W-1:0] == TIE_PAT) && !dst_val[HALF_W]) ? '0 : RND_TERM;
    neg_w  = add_c('0, ~dst_val, 1'b1);
    addend = '0;
    sum_w  = '0;
    res    = '0;
    carry  = 1'b0;
    ovf    = 1'b0;
    wr_en  = 1'b1;
    case (wacc_op_e'(op_code))
      OP_ADD, OP_INC: begin
        addend = (op_code == OP_INC) ? step : (op_alt ? low_val : src_val);
        sum_w  = add_c(dst_val, addend, 1'b0);
        res    = sum_w[ACC_W-1:0];
        carry  = sum_w[ACC_W];
        ovf    = add_ovf(dst_val[MSB], addend[MSB], res[MSB]);
      end
      OP_SUB, OP_CMP, OP_DEC: begin
        addend = (op_code == OP_DEC) ? step : src_val;
        sum_w  = add_c(dst_val, ~addend, 1'b1);
        res    = sum_w[ACC_W-1:0];
        carry  = sum_w[ACC_W];
        ovf    = (dst_val[MSB] != addend[MSB]) && (res[MSB] != dst_val[MSB]);
        wr_en  = (op_code != OP_CMP);
      end
      OP_MOVE: res = src_val;
      OP_ABSNEG: begin
        if (op_alt || dst_val[MSB]) begin
          res = neg_w[ACC_W-1:0];
          ovf = dst_val[MSB] && res[MSB];
        end else begin
          res = dst_val;
        end
        carry = op_alt && neg_w[ACC_W];
      end
      default: begin
        if (op_alt) begin
          res   = src_val;
          wr_en = 1'b0;
        end else begin
          sum_w = add_c(dst_val, term, 1'b0);
          res   = {sum_w[ACC_W-1:HALF_W], {HALF_W{1'b0}}};
          carry = sum_w[ACC_W];
          ovf   = !dst_val[MSB] && sum_w[MSB];
        end
      end
    endcase
  end

  always_comb begin
    if (op_code == OP_ABSNEG && !op_alt)
      AST_ABS_NONNEG: assert (!res[MSB] || ovf) else $error("abs result negative"); // R6
  end
endmodule

// File: rtl/wacc_flag_gen.sv
`timescale 1ns/1ps
module wacc_flag_gen
  import wacc_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int REG_W = 32
) (
  input  logic [ACC_W-1:0] res,
  input  logic             carry,
  input  logic             ovf,
  output wacc_flags_t      flg
);
  localparam int GUARD_W = ACC_W - REG_W + 1;
  logic [GUARD_W-1:0] guard;

  always_comb begin
    guard = res[ACC_W-1:REG_W-1];
    flg.c = carry;
    flg.v = ovf;
    flg.z = (res == '0);
    flg.n = res[ACC_W-1];
    flg.e = !((&guard) || !(|guard));
    flg.u = (res[REG_W-1] == res[REG_W-2]);
  end
endmodule

// File: rtl/wacc_alu.sv
`timescale 1ns/1ps
module wacc_alu
  import wacc_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic             op_alt,
  input  logic             dst_sel,
  input  logic [3:0]       src_sel,
  input  logic [REG_W-1:0] x_in,
  input  logic [REG_W-1:0] y_in,
  input  logic [ACC_W-1:0] prod_in,
  output logic [ACC_W-1:0] acc_a,
  output logic [ACC_W-1:0] acc_b,
  output logic [5:0]       flags
);
  localparam int HALF_W = REG_W / 2;

  logic [ACC_W-1:0] src_val;
  logic [ACC_W-1:0] low_val;
  logic [ACC_W-1:0] dst_val;
  logic [ACC_W-1:0] res;
  logic             carry;
  logic             ovf;
  logic             wr_en;
  wacc_flags_t      flg_next;
  wacc_flags_t      flg_q;
  logic             write_a;
  logic             write_b;

  assign dst_val = dst_sel ? acc_b : acc_a;
  assign write_a = op_valid && wr_en && !dst_sel;
  assign write_b = op_valid && wr_en && dst_sel;

  wacc_src_align #(.ACC_W(ACC_W), .REG_W(REG_W)) align_i (
    .src_sel(src_sel), .x_in(x_in), .y_in(y_in), .acc_a(acc_a), .acc_b(acc_b),
    .prod_in(prod_in), .src_val(src_val), .low_val(low_val)
  );

  wacc_arith #(.ACC_W(ACC_W), .HALF_W(HALF_W)) arith_i (
    .op_code(op_code), .op_alt(op_alt), .dst_val(dst_val), .src_val(src_val),
    .low_val(low_val), .res(res), .carry(carry), .ovf(ovf), .wr_en(wr_en)
  );

  wacc_flag_gen #(.ACC_W(ACC_W), .REG_W(REG_W)) flag_i (
    .res(res), .carry(carry), .ovf(ovf), .flg(flg_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_a <= '0;
      acc_b <= '0;
      flg_q <= '0;
    end else begin
      if (write_a) acc_a <= res;
      if (write_b) acc_b <= res;
      if (op_valid) flg_q <= flg_next;
    end
  end

  assign flags = flg_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc_a) && $stable(acc_b) && $stable(flags))); // R12
  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CMP) |=> ($stable(acc_a) && $stable(acc_b))); // R7
  AST_MOVE_CV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_MOVE) |=> (flags[1:0] == 2'b00)); // R8
  AST_RND_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_RNDTST && !op_alt) |=>
      ((($past(dst_sel)) ? acc_b[HALF_W-1:0] : acc_a[HALF_W-1:0]) == '0)); // R9
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    write_a |=> (flags[2] == (acc_a == '0))); // R10
  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    write_b |=> (flags[3] == acc_b[ACC_W-1])); // R10
endmodule

// File: tb/wacc_alu_tb.sv
`timescale 1ns/1ps
module wacc_alu_tb_top;
  localparam longint MASK = 64'h0000_00FF_FFFF_FFFF;
  localparam longint MAXP = 64'h0000_007F_FFFF_FFFF;
  localparam longint MINN = -64'sh0000_0080_0000_0000;

  typedef struct {
    logic [39:0] a;
    logic [39:0] b;
    logic [5:0]  f;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic        op_alt = 1'b0;
  logic        dst_sel = 1'b0;
  logic [3:0]  src_sel = '0;
  logic [31:0] x_in = '0;
  logic [31:0] y_in = '0;
  logic [39:0] prod_in = '0;
  logic [39:0] acc_a;
  logic [39:0] acc_b;
  logic [5:0]  flags;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  exp_t exp_q[$];
  longint ma = 0;
  longint mb = 0;
  logic [5:0] mf = '0;

  always #2.5 clk = ~clk;

  wacc_alu dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_alt(op_alt), .dst_sel(dst_sel), .src_sel(src_sel), .x_in(x_in),
    .y_in(y_in), .prod_in(prod_in), .acc_a(acc_a), .acc_b(acc_b), .flags(flags)
  );

  function automatic longint sx40(longint v);
    return ((v & MASK) <<< 24) >>> 24;
  endfunction

  task automatic push_exp(string tag);
    exp_t e;
    e.a = ma[39:0];
    e.b = mb[39:0];
    e.f = mf;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compares one queued expectation per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (acc_a !== e.a || acc_b !== e.b || flags !== e.f) begin
        failures++;
        $display("FAIL %s: a=%h exp %h, b=%h exp %h, flags=%b exp %b",
                 e.tag, acc_a, e.a, acc_b, e.b, flags, e.f);
      end
    end
  end

  task automatic run_op(input logic [2:0] op, input logic alt, input logic dst,
                        input logic [3:0] src, input logic [31:0] x,
                        input logic [31:0] y, input logic [39:0] p, input string tag);
    longint d, s, lo, o, rid, r;
    logic c, v, wr, rnd;
    logic [39:0] rr;
    op_code = op; op_alt = alt; dst_sel = dst; src_sel = src;
    x_in = x; y_in = y; prod_in = p; op_valid = 1'b1;
    d = sx40(dst ? mb : ma);
    case (src)
      4'd0: s = longint'($signed(x[15:0])) * 65536;
      4'd1: s = longint'($signed(y[15:0])) * 65536;
      4'd2: s = longint'($signed(x[31:16])) * 65536;
      4'd3: s = longint'($signed(y[31:16])) * 65536;
      4'd4: s = longint'($signed(x));
      4'd5: s = longint'($signed(y));
      4'd6: s = sx40(ma);
      4'd7: s = sx40(mb);
      4'd8: s = sx40(longint'(p));
      default: s = 0;
    endcase
    lo = (src == 4'd0) ? longint'(x[15:0]) : (src == 4'd1) ? longint'(y[15:0]) : 0;
    c = 0; wr = 1; rnd = 0; rid = 0;
    case (op)
      3'd0, 3'd4: begin
        o = (op == 3'd4) ? (alt ? 65536 : 1) : (alt ? lo : s);
        rid = d + o;
        c = (((d & MASK) + (o & MASK)) >> 40) != 0;
      end
      3'd1, 3'd2, 3'd5: begin
        o = (op == 3'd5) ? (alt ? 65536 : 1) : s;
        rid = d - o;
        c = (d & MASK) >= (o & MASK);
        wr = (op != 3'd2);
      end
      3'd3: rid = s;
      3'd6: begin
        if (alt) begin rid = -d; c = (d == 0); end
        else rid = (d < 0) ? -d : d;
      end
      default: begin
        if (alt) begin rid = s; wr = 0; end
        else begin
          o = (((d & 64'hFFFF) == 64'h8000) && ((d & 64'h10000) == 0)) ? 0 : 64'h8000;
          rid = d + o;
          c = (((d & MASK) + o) >> 40) != 0;
          rnd = 1;
        end
      end
    endcase
    v = (op == 3'd3 || (op == 3'd7 && alt)) ? 1'b0 : (rid > MAXP || rid < MINN);
    r = rid & MASK;
    if (rnd) r = r & ~64'hFFFF;
    rr = r[39:0];
    mf = {rr[31] == rr[30], !((&rr[39:31]) || !(|rr[39:31])), rr[39], rr == 0, v, c};
    if (wr) begin
      if (dst) mb = r; else ma = r;
    end
    @(posedge clk); #1;
    push_exp(tag);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic idle_cycle(input string tag);
    op_valid = 1'b0; op_code = 3'd0; src_sel = 4'd8; prod_in = 40'h12_3456_789A;
    @(posedge clk); #1;
    push_exp(tag);
    @(negedge clk);
  endtask

  task automatic load(input logic dst, input logic [39:0] p, input string tag);
    run_op(3'd3, 1'b0, dst, 4'd8, 32'h0, 32'h0, p, tag);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    push_exp("R1 reset state");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    load(1'b0, 40'h00_1234_5678, "R8 move product into A");
    load(1'b1, 40'hFF_8000_0000, "R8 move negative into B");
    run_op(3'd0, 0, 0, 4'd2, 32'h8000_0001, 32'h0, 40'h0, "R2 R3 add X high half");
    run_op(3'd0, 0, 0, 4'd0, 32'h0000_7FFF, 32'h0, 40'h0, "R2 add X low half");
    run_op(3'd1, 0, 1, 4'd5, 32'h0, 32'hFFFF_FFFE, 40'h0, "R2 R3 sub full Y");
    run_op(3'd0, 0, 1, 4'd4, 32'h8000_0000, 32'h0, 40'h0, "R2 R11 add full X");
    run_op(3'd0, 1, 0, 4'd1, 32'h0, 32'h0000_FFFF, 40'h0, "R4 long add Y low unsigned");
    run_op(3'd0, 0, 0, 4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 40'h0, "R2 unused code gives zero");
    load(1'b0, 40'h7F_FFFF_FFFF, "R8 load max");
    run_op(3'd4, 0, 0, 4'd0, 32'h0, 32'h0, 40'h0, "R5 R11 increment overflow");
    run_op(3'd5, 0, 0, 4'd0, 32'h0, 32'h0, 40'h0, "R5 R11 decrement back");
    run_op(3'd4, 1, 1, 4'd0, 32'h0, 32'h0, 40'h0, "R5 increment by middle step");
    run_op(3'd5, 1, 1, 4'd0, 32'h0, 32'h0, 40'h0, "R5 decrement by middle step");
    load(1'b0, 40'hFF_FFFF_FFFF, "R8 load all ones");
    run_op(3'd0, 0, 0, 4'd8, 32'h0, 32'h0, 40'h00_0000_0001, "R10 R11 add wraps to zero with carry");
    load(1'b1, 40'hF0_0000_1234, "R8 load negative B");
    run_op(3'd6, 0, 1, 4'd0, 32'h0, 32'h0, 40'h0, "R6 abs of negative");
    run_op(3'd6, 0, 1, 4'd0, 32'h0, 32'h0, 40'h0, "R6 abs of positive");
    load(1'b1, 40'h80_0000_0000, "R8 load most negative");
    run_op(3'd6, 1, 1, 4'd0, 32'h0, 32'h0, 40'h0, "R6 R11 negate most negative");
    run_op(3'd6, 0, 1, 4'd0, 32'h0, 32'h0, 40'h0, "R6 abs of most negative");
    load(1'b0, 40'h00_0000_0000, "R8 load zero");
    run_op(3'd6, 1, 0, 4'd0, 32'h0, 32'h0, 40'h0, "R6 R11 negate zero carry");
    load(1'b0, 40'h00_4000_0000, "R8 load A");
    run_op(3'd2, 0, 0, 4'd7, 32'h0, 32'h0, 40'h0, "R7 compare A with B");
    run_op(3'd2, 0, 0, 4'd6, 32'h0, 32'h0, 40'h0, "R7 compare A with itself");
    run_op(3'd7, 1, 0, 4'd3, 32'h0, 32'h8000_0000, 40'h0, "R8 test Y high");
    run_op(3'd7, 1, 1, 4'd8, 32'h0, 32'h0, 40'h00_0000_0000, "R8 R10 test zero product");
    load(1'b0, 40'h00_0001_8000, "R8 load tie odd");
    run_op(3'd7, 0, 0, 4'd0, 32'h0, 32'h0, 40'h0, "R9 round tie odd up");
    load(1'b0, 40'h00_0002_8000, "R8 load tie even");
    run_op(3'd7, 0, 0, 4'd0, 32'h0, 32'h0, 40'h0, "R9 round tie even stays");
    load(1'b1, 40'hFF_FFFF_7FFF, "R8 load below half");
    run_op(3'd7, 0, 1, 4'd0, 32'h0, 32'h0, 40'h0, "R9 round below half");
    load(1'b1, 40'h7F_FFFF_C000, "R8 load near max");
    run_op(3'd7, 0, 1, 4'd0, 32'h0, 32'h0, 40'h0, "R9 R11 round overflow");
    load(1'b0, 40'h00_C000_0000, "R10 extension and unnormalized bits");
    idle_cycle("R12 idle hold");
    idle_cycle("R12 idle hold again");

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: R12 run did not finish, got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule